// File: doc/BRIEF.md
# Mode-Dependent Pixel Byte Decoder

This block turns a stream of screen-memory bytes into a stream of 4-bit ink indices, one per pixel clock. Each byte covers eight pixel clocks. The pixel format depends on the display mode:

- **Mode 0:** the byte holds two 4-bit pixels.
- **Mode 1:** the byte holds four 2-bit pixels.
- **Mode 2:** the byte holds eight 1-bit pixels.

In every mode the bits of a pixel are interleaved across the byte instead of packed side by side. The block undoes that interleaving and presents the leftmost pixel first. A wide pixel is repeated for as many clocks as it spans.

The block is driven by a display-active input from the video timing logic. While that input is high, the block raises a byte request once every eight clocks. The memory side must present the next byte and the current mode in the same cycle as the request. Both are captured at the end of that cycle. Mode changes therefore take effect only at byte boundaries.

In every cycle that does not display a byte, the block raises a border flag and drives ink zero. This covers the cycles after blanking starts and the cycles before the first byte has been captured.

Top module: `pixel_byte_decoder`

## Requirements
- R1: `byte_req` is high exactly in those cycles where `active` is high and the number of consecutive active cycles before it is 0, 8, 16, and so on. `byte_in` and `mode_in` are captured at the clock edge that ends such a cycle.
- R2: A captured byte is displayed in the eight cycles that follow its capture, as slots 0 to 7, leftmost pixel in slot 0. Consecutive bytes in an active run are displayed back to back with no gap.
- R3: For mode code 0, slots 0-3 show {b1,b5,b3,b7} and slots 4-7 show {b0,b4,b2,b6}. In each group the first bit listed is the most significant bit of `ink_out`, and bN is bit N of the captured byte.
- R4: For mode code 1, slot pairs (0,1), (2,3), (4,5) and (6,7) show {b3,b7}, {b2,b6}, {b1,b5} and {b0,b4} respectively, in `ink_out[1:0]`, with `ink_out[3:2]` = 0.
- R5: For mode code 2, slot s shows bit 7-s of the byte in `ink_out[0]`, with `ink_out[3:1]` = 0.
- R6: Mode code 3 is decoded exactly as mode code 2.
- R7: A change of `mode_in` or `byte_in` in a cycle where `byte_req` is low has no effect on the pixels of the byte being displayed.
- R8: In a cycle that does not follow an active cycle, `border_out` is 1 and `ink_out` is 0. If `active` falls in the middle of a byte, the rest of that byte is dropped. When `active` rises again, the next active cycle starts a fresh byte request.
- R9: While `rst_n` is low, `border_out` is 1, `ink_out` is 0, and the byte counter returns to its start. After reset, the first active cycle raises `byte_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one pixel per cycle at the finest rate |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | High during the visible part of a line |
| byte_in | input | 8 | Screen-memory byte, valid in cycles where `byte_req` is high |
| mode_in | input | 2 | Display mode code, sampled together with `byte_in` |
| byte_req | output | 1 | Requests the next byte in this cycle |
| ink_out | output | 4 | Ink index of the current pixel, zero during border |
| border_out | output | 1 | High when no byte pixel is being displayed |

## Verification
The bench builds the block with its package constants: an 8-bit byte, a 4-bit ink and eight slots. These are the only values for which the interleaved bit order is defined, so every slot of every mode is reachable.

The bench feeds walking-one bytes and pseudo-random bytes in each mode. It also randomizes `mode_in` between requests to show that only sampled values matter. It drops `active` mid-byte and restarts it, to reach the partial-byte and restart corners.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int PBD_BYTE_W = 8;
  localparam int PBD_INK_W  = 4;
  localparam int PBD_SLOTS  = 8;
  localparam int PBD_SLOT_W = $clog2(PBD_SLOTS);

  typedef enum logic [1:0] {
    PBD_MODE_WIDE = 2'd0,
    PBD_MODE_MID  = 2'd1,
    PBD_MODE_FINE = 2'd2,
    PBD_MODE_RSVD = 2'd3
  } pbd_mode_e;

  // Gather the ink of one slot from the interleaved byte.
  function automatic logic [PBD_INK_W-1:0] pbd_pick(
    input logic [PBD_BYTE_W-1:0] b,
    input pbd_mode_e             m,
    input logic [PBD_SLOT_W-1:0] s
  );
    logic [2:0] p0;
    logic [2:0] p1;
    logic [PBD_INK_W-1:0] r;
    p0 = {2'b00, s[2]};
    p1 = {1'b0, s[2:1]};
    case (m)
      PBD_MODE_WIDE: r = {b[3'd1 - p0], b[3'd5 - p0], b[3'd3 - p0], b[3'd7 - p0]};
      PBD_MODE_MID:  r = {2'b00, b[3'd3 - p1], b[3'd7 - p1]};
      default:       r = {3'b000, b[3'd7 - s]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pbd_slot_ctr.sv
module pbd_slot_ctr
  import pbd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  output logic                  byte_req,
  output logic                  disp_on,
  output logic [PBD_SLOT_W-1:0] disp_slot
);
  logic [PBD_SLOT_W-1:0] fetch_cnt;

  assign byte_req = active && (fetch_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_cnt <= '0;
      disp_on   <= 1'b0;
      disp_slot <= '0;
    end else begin
      disp_on   <= active;
      disp_slot <= fetch_cnt;
      fetch_cnt <= active ? fetch_cnt + PBD_SLOT_W'(1) : '0;
    end
  end
endmodule

// File: rtl/pbd_byte_latch.sv
module pbd_byte_latch
  import pbd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [PBD_BYTE_W-1:0] byte_in,
  input  logic [1:0]            mode_in,
  output logic [PBD_BYTE_W-1:0] byte_q,
  output pbd_mode_e             mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q <= '0;
      mode_q <= PBD_MODE_MID;
    end else if (load) begin
      byte_q <= byte_in;
      mode_q <= pbd_mode_e'(mode_in);
    end
  end
endmodule

// File: rtl/pbd_pixel_sel.sv
module pbd_pixel_sel
  import pbd_pkg::*;
(
  input  logic [PBD_BYTE_W-1:0] byte_q,
  input  pbd_mode_e             mode_q,
  input  logic                  disp_on,
  input  logic [PBD_SLOT_W-1:0] disp_slot,
  output logic [PBD_INK_W-1:0]  ink,
  output logic                  border
);
  logic [PBD_INK_W-1:0] ink_tab [PBD_SLOTS];

  for (genvar g = 0; g < PBD_SLOTS; g++) begin : g_slot
    assign ink_tab[g] = pbd_pick(byte_q, mode_q, PBD_SLOT_W'(g));
  end

  assign ink    = disp_on ? ink_tab[disp_slot] : '0;
  assign border = !disp_on;
endmodule

// File: rtl/pixel_byte_decoder.sv
module pixel_byte_decoder
  import pbd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  input  logic [PBD_BYTE_W-1:0] byte_in,
  input  logic [1:0]            mode_in,
  output logic                  byte_req,
  output logic [PBD_INK_W-1:0]  ink_out,
  output logic                  border_out
);
  logic                  disp_on;
  logic [PBD_SLOT_W-1:0] disp_slot;
  logic [PBD_BYTE_W-1:0] byte_q;
  pbd_mode_e             mode_q;

  pbd_slot_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .byte_req  (byte_req),
    .disp_on   (disp_on),
    .disp_slot (disp_slot)
  );

  pbd_byte_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (byte_req),
    .byte_in (byte_in),
    .mode_in (mode_in),
    .byte_q  (byte_q),
    .mode_q  (mode_q)
  );

  pbd_pixel_sel u_sel (
    .byte_q    (byte_q),
    .mode_q    (mode_q),
    .disp_on   (disp_on),
    .disp_slot (disp_slot),
    .ink       (ink_out),
    .border    (border_out)
  );
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker
  import pbd_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  active,
  input logic                  byte_req,
  input logic [PBD_INK_W-1:0]  ink_out,
  input logic                  border_out,
  input pbd_mode_e             mode_q,
  input logic [PBD_SLOT_W-1:0] disp_slot
);
  AST_REQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |-> active);                                                    // R1
  AST_REQ_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_req |=> !byte_req);                                                 // R1
  AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!border_out && mode_q == PBD_MODE_MID && disp_slot[0])
      |-> ink_out == $past(ink_out));                                        // R4
  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!border_out && mode_q == PBD_MODE_WIDE && disp_slot[1:0] != 2'b00)
      |-> ink_out == $past(ink_out));                                        // R3
  AST_MID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PBD_MODE_MID) |-> ink_out[3:2] == 2'b00);                     // R4
  AST_FINE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1]) |-> ink_out[3:1] == 3'b000);                                 // R5
  AST_BLANK_BORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (border_out && ink_out == '0));                              // R8
endmodule

bind pixel_byte_decoder pbd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active),
  .byte_req   (byte_req),
  .ink_out    (ink_out),
  .border_out (border_out),
  .mode_q     (mode_q),
  .disp_slot  (disp_slot)
);

// File: tb/pixel_byte_decoder_tb.sv
module pixel_byte_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       active = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [1:0] mode_in = 2'd0;
  logic       byte_req;
  logic [3:0] ink_out;
  logic       border_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench-side model state
  logic [7:0] m_byte = 8'h00;
  logic [1:0] m_mode = 2'd0;
  logic       m_disp = 1'b0;
  int         m_slot = 0;
  int         act_cnt = 0;
  logic [7:0] lfsr = 8'hA5;
  int         walk = 0;
  string      cur_tag = "R2";

  pixel_byte_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .active(active), .byte_in(byte_in),
    .mode_in(mode_in), .byte_req(byte_req), .ink_out(ink_out),
    .border_out(border_out)
  );

  always #10 clk = ~clk;

  function automatic logic [3:0] exp_ink(input logic [7:0] b, input logic [1:0] m, input int s);
    logic [3:0] r;
    r = 4'h0;
    if (m == 2'd0) begin
      if (s < 4) r = {b[1], b[5], b[3], b[7]};
      else       r = {b[0], b[4], b[2], b[6]};
    end else if (m == 2'd1) begin
      case (s / 2)
        0: r = {2'b00, b[3], b[7]};
        1: r = {2'b00, b[2], b[6]};
        2: r = {2'b00, b[1], b[5]};
        default: r = {2'b00, b[0], b[4]};
      endcase
    end else begin
      r = {3'b000, b[7 - s]};
    end
    return r;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] next_byte();
    logic [7:0] r;
    if (walk < 8) begin
      r = 8'h01 << walk;
      walk++;
    end else begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      r = lfsr;
    end
    return r;
  endfunction

  // One pixel clock: check outputs, drive inputs, advance the model.
  task automatic step(input logic a, input logic [1:0] m, input bit rand_mode);
    logic req_exp;
    @(negedge clk);
    if (!m_disp) begin
      check("R8", "border", int'(border_out), 1);
      check("R8", "ink in border", int'(ink_out), 0);
    end else begin
      check(cur_tag, "border", int'(border_out), 0);
      check(cur_tag, "ink", int'(ink_out), int'(exp_ink(m_byte, m_mode, m_slot)));
    end
    active  = a;
    req_exp = a && (act_cnt % 8 == 0);
    mode_in = req_exp ? m : (rand_mode ? 2'(lfsr[2:1] ^ 2'(act_cnt)) : m);
    byte_in = req_exp ? next_byte() : ~byte_in;
    #1;
    check("R1", "byte_req", int'(byte_req), int'(req_exp));
    m_disp = a;
    m_slot = act_cnt % 8;
    if (req_exp) begin
      m_byte = byte_in;
      m_mode = mode_in;
    end
    act_cnt = a ? act_cnt + 1 : 0;
  endtask

  task automatic run_line(input int n_act, input logic [1:0] m, input bit rand_mode, input int n_idle);
    for (int i = 0; i < n_act; i++) step(1'b1, m, rand_mode);
    for (int i = 0; i < n_idle; i++) step(1'b0, m, 1'b0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    active = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "border in reset", int'(border_out), 1);
    check("R9", "ink in reset", int'(ink_out), 0);
    active = 1'b0;
    rst_n = 1'b1;
    m_disp = 1'b0;
    act_cnt = 0;
    cur_tag = "R9";
    run_line(16, 2'd2, 1'b0, 2);
  endtask

  task automatic t_fine();
    cur_tag = "R2,R5";
    run_line(96, 2'd2, 1'b0, 3);
  endtask

  task automatic t_mid();
    cur_tag = "R4";
    walk = 0;
    run_line(96, 2'd1, 1'b0, 3);
  endtask

  task automatic t_wide();
    cur_tag = "R3";
    walk = 0;
    run_line(96, 2'd0, 1'b0, 3);
  endtask

  task automatic t_rsvd();
    cur_tag = "R6";
    walk = 0;
    run_line(80, 2'd3, 1'b0, 2);
  endtask

  task automatic t_mode_noise();
    cur_tag = "R7";
    run_line(120, 2'd0, 1'b1, 2);
    run_line(120, 2'd1, 1'b1, 2);
  endtask

  task automatic t_midbyte_blank();
    cur_tag = "R8";
    run_line(13, 2'd1, 1'b0, 5);
    run_line(21, 2'd0, 1'b0, 1);
    run_line(35, 2'd2, 1'b0, 4);
  endtask

  initial begin
    t_reset();
    t_fine();
    t_mid();
    t_wide();
    t_rsvd();
    t_mode_noise();
    t_midbyte_blank();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule